// File: doc/BRIEF.md
# Receive Buffer Address Queue

This block sits on the receive side of a packet interface. It feeds received frames into memory buffers that software has supplied ahead of time. Software pushes buffer base addresses into a small address queue. When the first byte of a frame arrives on a byte-wide frame-in interface, the block takes the oldest address from the queue. It then writes every byte of the frame into that buffer at a programmed offset. After the last byte, it writes a 64-bit status word at the buffer's base address. The status word carries the byte count and the per-frame error and classification flags.

The block places its queue state in two words at fixed bit positions so that neighbouring logic can decode them: the read pointer, the write pointer and the entry count. It raises two events. The first is a threshold event that holds for as long as the entry count differs from a programmed value. The second is an underflow pulse that fires when a frame arrives while no buffer is available. Control arrives as one 16-bit word whose fields are fixed. The memory is modelled by two write ports: a byte port for payload and a 64-bit port for the status word.

Top module: `rx_bufq`

## Requirements
- R1: An asserted push_valid appends push_addr to the queue (default 16 entries), and addresses are consumed in arrival order. A push made while the queue is full is discarded, unless a pop happens in the same cycle.
- R2: A push and a pop in the same clock cycle both take effect and leave the entry count unchanged. This holds even when the queue is full.
- R3: fifo_info carries the write pointer in bits 19:16, the read pointer in bits 11:8 and the entry count in bits 4:0. irq_word carries the read pointer in bits 11:8. All other bits of both words read 0. The pointers wrap modulo the queue depth.
- R4: On the first byte of a frame, with reception enabled and the queue not empty, the head address B is popped. Byte i of the frame is written to B + 8*offset + 2 + i. The write appears on the data port (dat_we high) in the cycle after the byte is presented.
- R5: In the same cycle as the data write of a frame's last byte, sts_we writes a status word to address B. Its bit 63 is 1 and bits 15:0 hold the frame's byte count. frm_err bits 0..5 (code violation, CRC, bad preamble, long event, bad packet, carrier event) map to status bits 16, 18, 21, 22, 23 and 24. frm_cls bits 0..3 (multicast, broadcast, filter match, own-address match) map to bits 19, 20, 25 and 26. All other bits are 0.
- R6: ctrl bit 15 enables reception, bit 9 enables the threshold event, bits 14:12 are the data offset in 8-byte units, and bits 8:4 are the threshold depth. The enable and the offset are sampled at a frame's first byte and hold for the whole frame.
- R7: irq_word bit 5 is 1 exactly when ctrl bit 9 is set and the entry count differs from ctrl bits 8:4. rx_irq is the OR of irq_word bits 5 and 6.
- R8: A frame whose first byte arrives while the queue is empty sets irq_word bit 6 for exactly one cycle, one cycle after that byte. Such a frame pops nothing, and none of its bytes produce a data or status write.
- R9: A frame that starts while ctrl bit 15 is 0 is dropped whole. It causes no pop, no data or status write, and no underflow.
- R10: During and right after reset, the queue is empty, both pointers are 0, and no write strobes are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 16 | Control word (enable, event enable, offset, depth) |
| push_valid | input | 1 | Push a buffer address this cycle |
| push_addr | input | AW | Buffer base address to push |
| frm_valid | input | 1 | A frame byte is present |
| frm_byte | input | 8 | Frame byte |
| frm_last | input | 1 | Marks the last byte of a frame |
| frm_err | input | 6 | Error flags, sampled with the last byte |
| frm_cls | input | 4 | Classification flags, sampled with the last byte |
| dat_we | output | 1 | Payload byte write strobe |
| dat_addr | output | AW | Payload byte address |
| dat_byte | output | 8 | Payload byte |
| sts_we | output | 1 | Status word write strobe |
| sts_addr | output | AW | Status word address (buffer base) |
| sts_vec | output | 64 | Status word |
| irq_word | output | 16 | Event word: read pointer, underflow, threshold |
| fifo_info | output | 20 | Queue word: write pointer, read pointer, count |
| rx_irq | output | 1 | Either event active |

## Verification
A wrong count or a wrong pointer is visible in fifo_info and in threshold bit 5 from the very next clock. A buffer popped at the wrong time shows up as a shifted read pointer and, later, as a data or status write landing at another frame's base address. A drifting write cursor or byte count first appears on dat_addr in the cycle after the offending byte. At the latest, it appears in the status word one cycle after the frame's last byte. Comparing every port against a behavioural model on every clock therefore pins each fault to the cycle where it becomes observable.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

   // control word field positions (decoded by neighbouring logic)
   localparam int CTL_RX_EN  = 15;
   localparam int CTL_IRQ_EN = 9;
   localparam int CTL_OFF_LO = 12;
   localparam int CTL_OFF_W  = 3;
   localparam int CTL_DEP_LO = 4;
   localparam int CTL_DEP_W  = 5;

   // event word and queue word field positions
   localparam int EVT_THR    = 5;
   localparam int EVT_UNF    = 6;
   localparam int EVT_RP_LO  = 8;
   localparam int INF_WP_LO  = 16;
   localparam int INF_RP_LO  = 8;
   localparam int INF_CNT_LO = 0;
   localparam int PTR_FLD_W  = 4;
   localparam int CNT_FLD_W  = 5;

   // two bytes of pad between the offset area and the payload
   localparam int PAD_BYTES  = 2;
   localparam int LEN_W      = 16;

   typedef struct packed {
      logic carrier;
      logic bad;
      logic longev;
      logic preamble;
      logic crc;
      logic code;
   } rx_err_t;

   typedef struct packed {
      logic own_hit;
      logic filt_hit;
      logic bcast;
      logic mcast;
   } rx_cls_t;

   typedef struct packed {
      logic                  rx_en;
      logic                  evt_en;
      logic [CTL_OFF_W-1:0]  off;
      logic [CTL_DEP_W-1:0]  depth;
   } rx_cfg_t;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_FILL = 2'd1,
      FS_SKIP = 2'd2
   } fstate_t;

   function automatic logic [63:0] pack_status(input logic [LEN_W-1:0] len,
                                               input rx_err_t e,
                                               input rx_cls_t c);
      logic [63:0] v;
      v          = '0;
      v[63]      = 1'b1;
      v[26]      = c.own_hit;
      v[25]      = c.filt_hit;
      v[24]      = e.carrier;
      v[23]      = e.bad;
      v[22]      = e.longev;
      v[21]      = e.preamble;
      v[20]      = c.bcast;
      v[19]      = c.mcast;
      v[18]      = e.crc;
      v[16]      = e.code;
      v[15:0]    = len;
      return v;
   endfunction

endpackage

// File: rtl/rxq_addr_fifo.sv
`timescale 1ns/1ps
module rxq_addr_fifo #(
   parameter int DEPTH = 16,
   parameter int AW    = 64,
   parameter int PW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic          pop,
   output logic [AW-1:0] head,
   output logic [CW-1:0] count,
   output logic [PW-1:0] rd_ptr,
   output logic [PW-1:0] wr_ptr,
   output logic          empty
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic          full;
   logic          pop_ok;
   logic          push_ok;
   logic [AW-1:0] slot_w [DEPTH];

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign pop_ok  = pop & ~empty;
   // a pop in the same cycle frees the slot the push needs
   assign push_ok = push & (~full | pop_ok);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [AW-1:0] q_r;
      always_ff @(posedge clk) begin
         if (push_ok && wr_ptr == PW'(i)) begin
            q_r <= push_addr;
         end
      end
      assign slot_w[i] = q_r;
   end

   assign head = slot_w[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (pop_ok) begin
            rd_ptr <= rd_ptr + PW'(1);
         end
         if (push_ok) begin
            wr_ptr <= wr_ptr + PW'(1);
         end
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/rxq_frame_wr.sv
`timescale 1ns/1ps
module rxq_frame_wr
   import rxq_pkg::*;
#(
   parameter int AW = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_en,
   input  logic [CTL_OFF_W-1:0] off,
   input  logic                 frm_valid,
   input  logic [7:0]           frm_byte,
   input  logic                 frm_last,
   input  rx_err_t              frm_err,
   input  rx_cls_t              frm_cls,
   input  logic [AW-1:0]        head,
   input  logic                 q_empty,
   output logic                 pop,
   output logic                 unf_pulse,
   output logic                 dat_we,
   output logic [AW-1:0]        dat_addr,
   output logic [7:0]           dat_byte,
   output logic                 sts_we,
   output logic [AW-1:0]        sts_addr,
   output logic [63:0]          sts_vec
);

   fstate_t          st;
   logic [AW-1:0]    base_q;
   logic [AW-1:0]    cur_q;
   logic [LEN_W-1:0] len_q;

   logic             start;
   logic             take;
   logic [AW-1:0]    first_addr;

   assign start      = frm_valid && (st == FS_IDLE);
   assign take       = start && rx_en && !q_empty;
   assign pop        = take;
   // offset counts 8-byte units, then the fixed pad
   assign first_addr = head + AW'({off, 3'b000}) + AW'(PAD_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= FS_IDLE;
         base_q    <= '0;
         cur_q     <= '0;
         len_q     <= '0;
         unf_pulse <= 1'b0;
         dat_we    <= 1'b0;
         dat_addr  <= '0;
         dat_byte  <= '0;
         sts_we    <= 1'b0;
         sts_addr  <= '0;
         sts_vec   <= '0;
      end else begin
         dat_we    <= 1'b0;
         sts_we    <= 1'b0;
         unf_pulse <= 1'b0;
         case (st)
            FS_IDLE: begin
               if (frm_valid) begin
                  if (!rx_en) begin
                     if (!frm_last) st <= FS_SKIP;
                  end else if (q_empty) begin
                     unf_pulse <= 1'b1;
                     if (!frm_last) st <= FS_SKIP;
                  end else begin
                     dat_we   <= 1'b1;
                     dat_addr <= first_addr;
                     dat_byte <= frm_byte;
                     cur_q    <= first_addr + AW'(1);
                     base_q   <= head;
                     len_q    <= LEN_W'(1);
                     if (frm_last) begin
                        sts_we   <= 1'b1;
                        sts_addr <= head;
                        sts_vec  <= pack_status(LEN_W'(1), frm_err, frm_cls);
                     end else begin
                        st <= FS_FILL;
                     end
                  end
               end
            end
            FS_FILL: begin
               if (frm_valid) begin
                  dat_we   <= 1'b1;
                  dat_addr <= cur_q;
                  dat_byte <= frm_byte;
                  cur_q    <= cur_q + AW'(1);
                  len_q    <= len_q + LEN_W'(1);
                  if (frm_last) begin
                     sts_we   <= 1'b1;
                     sts_addr <= base_q;
                     sts_vec  <= pack_status(len_q + LEN_W'(1), frm_err, frm_cls);
                     st       <= FS_IDLE;
                  end
               end
            end
            FS_SKIP: begin
               if (frm_valid && frm_last) st <= FS_IDLE;
            end
            default: st <= FS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rxq_evt.sv
`timescale 1ns/1ps
module rxq_evt
   import rxq_pkg::*;
#(
   parameter int PW = 4,
   parameter int CW = 5
) (
   input  logic [CW-1:0]        count,
   input  logic [PW-1:0]        rd_ptr,
   input  logic [PW-1:0]        wr_ptr,
   input  logic                 evt_en,
   input  logic [CTL_DEP_W-1:0] depth,
   input  logic                 unf_pulse,
   output logic [15:0]          irq_word,
   output logic [19:0]          fifo_info,
   output logic                 rx_irq
);

   logic thr;

   assign thr = evt_en && (CNT_FLD_W'(count) != depth);

   always_comb begin
      irq_word                                 = '0;
      irq_word[EVT_THR]                        = thr;
      irq_word[EVT_UNF]                        = unf_pulse;
      irq_word[EVT_RP_LO +: PTR_FLD_W]         = PTR_FLD_W'(rd_ptr);

      fifo_info                                = '0;
      fifo_info[INF_WP_LO +: PTR_FLD_W]        = PTR_FLD_W'(wr_ptr);
      fifo_info[INF_RP_LO +: PTR_FLD_W]        = PTR_FLD_W'(rd_ptr);
      fifo_info[INF_CNT_LO +: CNT_FLD_W]       = CNT_FLD_W'(count);
   end

   assign rx_irq = thr | unf_pulse;

endmodule

// File: rtl/rx_bufq.sv
`timescale 1ns/1ps
module rx_bufq
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [15:0]   ctrl,
   input  logic          push_valid,
   input  logic [AW-1:0] push_addr,
   input  logic          frm_valid,
   input  logic [7:0]    frm_byte,
   input  logic          frm_last,
   input  logic [5:0]    frm_err,
   input  logic [3:0]    frm_cls,
   output logic          dat_we,
   output logic [AW-1:0] dat_addr,
   output logic [7:0]    dat_byte,
   output logic          sts_we,
   output logic [AW-1:0] sts_addr,
   output logic [63:0]   sts_vec,
   output logic [15:0]   irq_word,
   output logic [19:0]   fifo_info,
   output logic          rx_irq
);

   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || DEPTH > 16) begin : g_bad_depth
      $error("rx_bufq: DEPTH must lie in 2..16 to fit the 4-bit pointer fields");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("rx_bufq: DEPTH must be a power of two");
   end
   if (AW < 16 || AW > 64) begin : g_bad_aw
      $error("rx_bufq: AW must lie in 16..64");
   end

   rx_cfg_t       cfg;
   logic          unused_ctrl;
   logic [AW-1:0] fifo_head;
   logic [CW-1:0] fifo_cnt;
   logic [PW-1:0] fifo_rp;
   logic [PW-1:0] fifo_wp;
   logic          fifo_empty;
   logic          fifo_pop;
   logic          unf_pulse;

   assign cfg.rx_en  = ctrl[CTL_RX_EN];
   assign cfg.evt_en = ctrl[CTL_IRQ_EN];
   assign cfg.off    = ctrl[CTL_OFF_LO +: CTL_OFF_W];
   assign cfg.depth  = ctrl[CTL_DEP_LO +: CTL_DEP_W];
   assign unused_ctrl = ^{ctrl[11:10], ctrl[3:0]};

   rxq_addr_fifo #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .CW(CW)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_valid),
      .push_addr (push_addr),
      .pop       (fifo_pop),
      .head      (fifo_head),
      .count     (fifo_cnt),
      .rd_ptr    (fifo_rp),
      .wr_ptr    (fifo_wp),
      .empty     (fifo_empty)
   );

   rxq_frame_wr #(.AW(AW)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (cfg.rx_en),
      .off       (cfg.off),
      .frm_valid (frm_valid),
      .frm_byte  (frm_byte),
      .frm_last  (frm_last),
      .frm_err   (rx_err_t'(frm_err)),
      .frm_cls   (rx_cls_t'(frm_cls)),
      .head      (fifo_head),
      .q_empty   (fifo_empty),
      .pop       (fifo_pop),
      .unf_pulse (unf_pulse),
      .dat_we    (dat_we),
      .dat_addr  (dat_addr),
      .dat_byte  (dat_byte),
      .sts_we    (sts_we),
      .sts_addr  (sts_addr),
      .sts_vec   (sts_vec)
   );

   rxq_evt #(.PW(PW), .CW(CW)) u_evt (
      .count     (fifo_cnt),
      .rd_ptr    (fifo_rp),
      .wr_ptr    (fifo_wp),
      .evt_en    (cfg.evt_en),
      .depth     (cfg.depth),
      .unf_pulse (unf_pulse),
      .irq_word  (irq_word),
      .fifo_info (fifo_info),
      .rx_irq    (rx_irq)
   );

endmodule

// File: rtl/rx_bufq_chk.sv
`timescale 1ns/1ps
module rx_bufq_chk #(
   parameter int DEPTH = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        pop,
   input logic        push_valid,
   input logic        sts_we,
   input logic [63:0] sts_vec,
   input logic [15:0] irq_word,
   input logic [19:0] fifo_info
);

   // R1
   cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fifo_info[4:0]) <= DEPTH)
      else $error("count above depth");

   // R2
   push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && push_valid) |=> $stable(fifo_info[4:0]))
      else $error("count moved on simultaneous push and pop");

   // R4
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> 32'(fifo_info[11:8]) == ((32'($past(fifo_info[11:8])) + 1) % DEPTH))
      else $error("read pointer did not advance by one");

   // R5
   sts_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_we |-> sts_vec[63])
      else $error("status word written without valid bit");

   // R8
   unf_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_word[6] |-> ($past(fifo_info[4:0]) == 5'd0))
      else $error("underflow while buffers were available");

   // R8
   unf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_word[6] |=> !irq_word[6] || ($past(fifo_info[4:0]) == 5'd0))
      else $error("underflow held without a new empty start");

endmodule

bind rx_bufq rx_bufq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pop        (fifo_pop),
   .push_valid (push_valid),
   .sts_we     (sts_we),
   .sts_vec    (sts_vec),
   .irq_word   (irq_word),
   .fifo_info  (fifo_info)
);

// File: tb/sim_rx_bufq.sv
`timescale 1ns/1ps
module sim_rx_bufq;

   localparam real CLK_NS = 5.0;
   localparam int  NQ     = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctrl = '0;
   logic        push_valid = 1'b0;
   logic [63:0] push_addr = '0;
   logic        frm_valid = 1'b0;
   logic [7:0]  frm_byte = '0;
   logic        frm_last = 1'b0;
   logic [5:0]  frm_err = '0;
   logic [3:0]  frm_cls = '0;
   logic        dat_we;
   logic [63:0] dat_addr;
   logic [7:0]  dat_byte;
   logic        sts_we;
   logic [63:0] sts_addr;
   logic [63:0] sts_vec;
   logic [15:0] irq_word;
   logic [19:0] fifo_info;
   logic        rx_irq;

   always #(CLK_NS / 2.0) clk = ~clk;

   rx_bufq u0 (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
      .push_valid(push_valid), .push_addr(push_addr),
      .frm_valid(frm_valid), .frm_byte(frm_byte), .frm_last(frm_last),
      .frm_err(frm_err), .frm_cls(frm_cls),
      .dat_we(dat_we), .dat_addr(dat_addr), .dat_byte(dat_byte),
      .sts_we(sts_we), .sts_addr(sts_addr), .sts_vec(sts_vec),
      .irq_word(irq_word), .fifo_info(fifo_info), .rx_irq(rx_irq)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    cmp_on = 0;
   bit    done = 0;
   string ctx = "R1 R4 R5";

   // ---------------- behavioural reference ----------------
   logic [63:0] q[$];
   int          rp, wp, ms, mlen;
   logic [63:0] mbase, mcur;
   logic        e_dwe, e_swe, e_unf;
   logic [63:0] e_daddr, e_saddr, e_svec;
   logic [7:0]  e_dbyte;

   function automatic logic [63:0] ref_status(int len, logic [5:0] e, logic [3:0] c);
      logic [63:0] v = '0;
      v[63] = 1'b1; v[15:0] = 16'(len);
      v[16] = e[0]; v[18] = e[1]; v[21] = e[2];
      v[22] = e[3]; v[23] = e[4]; v[24] = e[5];
      v[19] = c[0]; v[20] = c[1]; v[25] = c[2]; v[26] = c[3];
      return v;
   endfunction

   task automatic model_reset();
      q.delete(); rp = 0; wp = 0; ms = 0; mlen = 0;
      mbase = '0; mcur = '0;
      e_dwe = 0; e_swe = 0; e_unf = 0;
      e_daddr = '0; e_saddr = '0; e_svec = '0; e_dbyte = '0;
   endtask

   task automatic model_step();
      logic [63:0] b, a;
      e_dwe = 0; e_swe = 0; e_unf = 0;
      if (frm_valid) begin
         case (ms)
            0: begin
               if (!ctrl[15]) begin
                  ms = frm_last ? 0 : 2;
               end else if (q.size() == 0) begin
                  e_unf = 1;
                  ms = frm_last ? 0 : 2;
               end else begin
                  b = q.pop_front();
                  rp = (rp + 1) % NQ;
                  a = b + 64'(ctrl[14:12]) * 8 + 2;
                  e_dwe = 1; e_daddr = a; e_dbyte = frm_byte;
                  mcur = a + 1; mbase = b; mlen = 1;
                  if (frm_last) begin
                     e_swe = 1; e_saddr = b; e_svec = ref_status(1, frm_err, frm_cls);
                  end else ms = 1;
               end
            end
            1: begin
               e_dwe = 1; e_daddr = mcur; e_dbyte = frm_byte;
               mcur = mcur + 1; mlen = mlen + 1;
               if (frm_last) begin
                  e_swe = 1; e_saddr = mbase; e_svec = ref_status(mlen, frm_err, frm_cls);
                  ms = 0;
               end
            end
            default: if (frm_last) ms = 0;
         endcase
      end
      if (push_valid && q.size() < NQ) begin
         q.push_back(push_addr);
         wp = (wp + 1) % NQ;
      end
   endtask

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] at %0t: actual %h expected %h", tag, ctx, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      logic        thr;
      logic [15:0] ew;
      logic [19:0] ei;
      thr = ctrl[9] && (q.size() != int'(ctrl[8:4]));
      ew  = (16'(rp) << 8) | (16'(e_unf) << 6) | (16'(thr) << 5);
      ei  = (20'(wp) << 16) | (20'(rp) << 8) | 20'(q.size());
      chk("R1 R3 fifo_info", 64'(fifo_info), 64'(ei));
      chk("R3 R7 R8 irq_word", 64'(irq_word), 64'(ew));
      chk("R7 rx_irq", 64'(rx_irq), 64'(thr | e_unf));
      chk("R4 dat_we", 64'(dat_we), 64'(e_dwe));
      if (e_dwe) begin
         chk("R4 dat_addr", dat_addr, e_daddr);
         chk("R4 dat_byte", 64'(dat_byte), 64'(e_dbyte));
      end
      chk("R5 sts_we", 64'(sts_we), 64'(e_swe));
      if (e_swe) begin
         chk("R5 sts_addr", sts_addr, e_saddr);
         chk("R5 sts_vec", sts_vec, e_svec);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_step();
      #1;
      if (rst_n && cmp_on) compare_all();
   end

   // ---------------- stimulus ----------------
   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         push_valid = 0; frm_valid = 0; frm_last = 0; frm_err = '0; frm_cls = '0;
      end
   endtask

   task automatic push(logic [63:0] a);
      @(negedge clk);
      frm_valid = 0; frm_last = 0;
      push_valid = 1; push_addr = a;
   endtask

   task automatic frame(int n, logic [5:0] e, logic [3:0] c,
                        bit with_push = 0, logic [63:0] pa = '0);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frm_valid = 1; frm_byte = 8'($urandom);
         frm_last  = (i == n - 1);
         frm_err   = frm_last ? e : 6'($urandom);
         frm_cls   = frm_last ? c : 4'($urandom);
         push_valid = with_push && (i == 0);
         push_addr  = pa;
      end
   endtask

   function automatic logic [63:0] buf_addr(int k);
      return 64'h0000_0040_0000_0000 + 64'(k) * 64'h1000 + 64'(k * 8);
   endfunction

   function automatic logic [15:0] mk_ctrl(bit en, bit ie, int off, int dep);
      return (16'(en) << 15) | (16'(ie) << 9) | (16'(off) << 12) | (16'(dep) << 4);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state at the ports
      chk("R10 fifo_info in reset", 64'(fifo_info), 64'd0);
      chk("R10 irq_word in reset", 64'(irq_word), 64'd0);
      chk("R10 strobes in reset", 64'({dat_we, sts_we}), 64'd0);
      rst_n = 1;
      cmp_on = 1;
      idle(1);
      chk("R10 fifo_info after reset", 64'(fifo_info), 64'd0);

      ctrl = mk_ctrl(1, 1, 4, 2);
      ctx = "R1 R4 R5";
      for (int k = 0; k < 3; k++) push(buf_addr(k));
      idle(1);
      frame(6, 6'b000000, 4'b0001);
      idle(1);
      frame(1, 6'b000010, 4'b1000);
      idle(1);

      ctx = "R7";
      ctrl = mk_ctrl(1, 1, 4, 1);
      idle(2);

      ctx = "R2";
      frame(3, 6'b100101, 4'b0110, 1, buf_addr(3));
      idle(1);
      chk("R2 count after push+pop", 64'(fifo_info[4:0]), 64'd1);

      ctx = "R1";
      for (int k = 4; k < 21; k++) push(buf_addr(k));
      idle(1);
      chk("R1 full count", 64'(fifo_info[4:0]), 64'd16);

      ctx = "R2";
      frame(2, 6'b111111, 4'b1111, 1, buf_addr(40));
      idle(1);
      chk("R2 count when full", 64'(fifo_info[4:0]), 64'd16);

      ctx = "R6";
      ctrl = mk_ctrl(1, 1, 0, 16);
      frame(4, 6'b011000, 4'b0100);
      idle(1);
      ctrl = mk_ctrl(1, 1, 7, 16);
      frame(3, 6'b000001, 4'b0010);
      // change offset while the next frame is in flight
      frame(1, 6'b0, 4'b0);
      frame(3, 6'b0, 4'b0);
      @(negedge clk);
      ctrl = mk_ctrl(1, 1, 1, 16);
      frame(2, 6'b000100, 4'b0001);
      idle(1);

      ctx = "R9";
      ctrl = mk_ctrl(0, 1, 3, 9);
      frame(5, 6'b0, 4'b0);
      idle(1);
      chk("R9 count after dropped frame", 64'(fifo_info[4:0]), 64'(q.size()));
      chk("R9 no write after dropped frame", 64'({dat_we, sts_we}), 64'd0);

      ctx = "R8";
      ctrl = mk_ctrl(1, 1, 2, 0);
      while (q.size() > 0) begin
         frame(1, 6'b0, 4'b0);
      end
      idle(1);
      frame(4, 6'b0, 4'b0);
      idle(2);
      frame(2, 6'b0, 4'b0, 1, buf_addr(50));
      idle(2);
      chk("R8 push during underflow start kept", 64'(fifo_info[4:0]), 64'd1);

      ctx = "R7";
      ctrl = mk_ctrl(1, 0, 2, 0);
      idle(2);
      ctrl = mk_ctrl(1, 1, 2, 1);
      idle(2);

      cmp_on = 0;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000.0);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog [%s]: actual hung expected finished", ctx);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule